// File: doc/BRIEF.md
# Bit-Serial Nonlinear Keystream Generator

This block is a bit-serial stream cipher core built from two 80-bit shift registers, one with linear and one with nonlinear feedback. A start pulse loads an 80-bit key and a 64-bit IV. The core then mixes the state for 160 clocks without emitting anything. After that it produces one keystream bit per clock, and a valid flag marks each bit.

A fault-injection test port can invert one selected bit of the linear register on any keystream clock. A second start with the same key and IV reproduces the run exactly. Comparing a faulted run against a clean one shows how a single-bit disturbance spreads into the keystream.

Top module: `grain_keystream`

## Requirements
- R1: The clock edge that samples `start` high loads the key into the nonlinear register (key bit i to nonlinear bit i), IV bit i into linear bit i for i in 0..63, and ones into linear bits 64..79.
- R2: `ksValid` stays low for the load clock and for the 160 mixing clocks that follow. It goes high on the next cycle and remains high while the core runs.
- R3: The output bit is z = h ^ x1 ^ x2 ^ x4 ^ x10 ^ x31 ^ x43 ^ x56. Here h(s0..s4) = s1+s4+s0s3+s2s3+s3s4+s0s1s2+s0s2s3+s0s2s4+s1s2s4+s2s3s4 over GF(2), with s0=y3, s1=y25, s2=y46, s3=y64 and s4=x63 (x is the nonlinear register, y the linear one).
- R4: During the 160 mixing clocks, z is XORed into both feedback bits. Once the keystream phase begins, this feedback is removed.
- R5: Both registers shift toward index 0, and the feedback enters at index 79. The linear feedback is y0^y13^y23^y38^y51^y62. The nonlinear feedback is y0 ^ g(x), with g as the 11 linear taps 0,9,14,21,28,33,37,45,52,60,62 plus the 11 product terms x63x60, x37x33, x15x9, x60x52x45, x33x28x21, x63x45x28x9, x60x52x37x33, x63x60x21x15, x63x60x52x45x37, x33x28x21x15x9, x52x45x37x33x28x21.
- R6: Assert `faultEn` on a valid cycle with `faultIdx` below 80, and linear bit `faultIdx` is inverted before that cycle's output and update. While `ksValid` is low, `faultEn` has no effect.
- R7: Faults may be applied on several keystream cycles of the same run, and each one inverts the bit currently held at the chosen index.
- R8: A `start` pulse at any time restarts from key and IV. `ksValid` is low in the following cycle, and the same key and IV give the same keystream.
- R9: After reset `ready` is high and `ksValid` is low. `ready` is low exactly while the mixing phase runs.
- R10: A `faultIdx` of 80 or more leaves the state and the keystream unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load key and IV and begin mixing |
| keyIn | input | 80 | Key, bit i to nonlinear bit i |
| ivIn | input | 64 | IV, bit i to linear bit i |
| faultEn | input | 1 | Invert one linear bit this cycle |
| faultIdx | input | 7 | Index of the linear bit to invert |
| ksBit | output | 1 | Keystream bit (combinational from state and fault) |
| ksValid | output | 1 | `ksBit` is a keystream bit |
| ready | output | 1 | Core is not in its mixing phase |

## Verification
The assertions assume that `keyIn` and `ivIn` hold steady on the cycle `start` is high. They also assume that `faultIdx` is stable while `faultEn` is high, because both the fault check and the shift check compare the register against its value one cycle earlier. The bench drives every input on the falling edge and sets the key and IV before it raises `start`. It raises `faultEn` only on chosen cycles, and when it does so during mixing it does so on purpose, to show that the fault has no effect there. Out-of-range indices are driven to show that they are ignored.

// File: rtl/grain_pkg.sv
package grain_pkg;
  typedef struct packed {
    logic load;    // take key and IV this edge
    logic step;    // shift both registers this edge
    logic mixOut;  // feed output bit back (mixing phase)
  } dpCtrl_t;
endpackage

// File: rtl/grain_ctrl.sv
module grain_ctrl
  import grain_pkg::*;
#(
  parameter int INIT_CLKS = 160
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output dpCtrl_t ctl,
  output logic    ksValid,
  output logic    ready
);
  localparam int CNT_W = $clog2(INIT_CLKS);

  typedef enum logic [1:0] {ST_IDLE, ST_MIX, ST_RUN} phase_t;
  phase_t           phase;
  logic [CNT_W-1:0] mixCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= ST_IDLE;
      mixCnt <= '0;
    end else if (start) begin
      phase  <= ST_MIX;
      mixCnt <= '0;
    end else if (phase == ST_MIX) begin
      mixCnt <= mixCnt + 1'b1;
      if (mixCnt == CNT_W'(INIT_CLKS - 1)) phase <= ST_RUN;
    end
  end

  always_comb begin
    ctl.load   = start;
    ctl.step   = !start && (phase != ST_IDLE);
    ctl.mixOut = (phase == ST_MIX);
    ksValid    = (phase == ST_RUN);
    ready      = (phase != ST_MIX);
  end

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ksValid) |-> ($past(phase) == ST_MIX && $past(mixCnt) == CNT_W'(INIT_CLKS - 1)));

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (!ksValid && !ready));
endmodule

// File: rtl/grain_datapath.sv
module grain_datapath
  import grain_pkg::*;
#(
  parameter int REG_W = 80,
  parameter int IV_W  = 64,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctl,
  input  logic [REG_W-1:0] keyIn,
  input  logic [IV_W-1:0]  ivIn,
  input  logic             faultArm,
  input  logic             faultEn,
  input  logic [IDX_W-1:0] faultIdx,
  output logic             zBit
);
  localparam int PAD_W = REG_W - IV_W;

  logic [REG_W-1:0] nlReg, linReg, linEff, faultMask;
  logic             faultHit, hVal, linFb, nlFb, mixBit;

  function automatic logic gFun(input logic [REG_W-1:0] x);
    logic lin, prod;
    lin  = x[0] ^ x[9] ^ x[14] ^ x[21] ^ x[28] ^ x[33] ^ x[37] ^ x[45]
         ^ x[52] ^ x[60] ^ x[62];
    prod = (x[63] & x[60]) ^ (x[37] & x[33]) ^ (x[15] & x[9])
         ^ (x[60] & x[52] & x[45]) ^ (x[33] & x[28] & x[21])
         ^ (x[63] & x[45] & x[28] & x[9]) ^ (x[60] & x[52] & x[37] & x[33])
         ^ (x[63] & x[60] & x[21] & x[15])
         ^ (x[63] & x[60] & x[52] & x[45] & x[37])
         ^ (x[33] & x[28] & x[21] & x[15] & x[9])
         ^ (x[52] & x[45] & x[37] & x[33] & x[28] & x[21]);
    return lin ^ prod;
  endfunction

  function automatic logic hFun(input logic s0, s1, s2, s3, s4);
    return s1 ^ s4 ^ (s0 & s3) ^ (s2 & s3) ^ (s3 & s4) ^ (s0 & s1 & s2)
         ^ (s0 & s2 & s3) ^ (s0 & s2 & s4) ^ (s1 & s2 & s4) ^ (s2 & s3 & s4);
  endfunction

  always_comb begin
    faultHit  = faultArm && faultEn && (int'(faultIdx) < REG_W);
    faultMask = faultHit ? (REG_W'(1) << faultIdx) : '0;
    linEff    = linReg ^ faultMask;
    hVal      = hFun(linEff[3], linEff[25], linEff[46], linEff[64], nlReg[63]);
    zBit      = hVal ^ nlReg[1] ^ nlReg[2] ^ nlReg[4] ^ nlReg[10]
              ^ nlReg[31] ^ nlReg[43] ^ nlReg[56];
    mixBit    = ctl.mixOut & zBit;
    linFb     = linEff[0] ^ linEff[13] ^ linEff[23] ^ linEff[38]
              ^ linEff[51] ^ linEff[62] ^ mixBit;
    nlFb      = linEff[0] ^ gFun(nlReg) ^ mixBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nlReg  <= '0;
      linReg <= '0;
    end else if (ctl.load) begin
      nlReg  <= keyIn;
      linReg <= {{PAD_W{1'b1}}, ivIn};
    end else if (ctl.step) begin
      nlReg  <= {nlFb, nlReg[REG_W-1:1]};
      linReg <= {linFb, linEff[REG_W-1:1]};
    end
  end

  // R1
  load_map_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (nlReg == $past(keyIn) && linReg[IV_W-1:0] == $past(ivIn)
                  && (&linReg[REG_W-1:IV_W])));

  // R5
  shift_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && !faultHit) |=> (linReg[REG_W-2:0] == $past(linReg[REG_W-1:1])
                                 && nlReg[REG_W-2:0] == $past(nlReg[REG_W-1:1])));

  // R6
  fault_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && faultHit && faultIdx != '0) |=>
      (linReg[$past(faultIdx) - 1'b1] != $past(linReg[faultIdx])));

  // R4
  mix_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultArm |-> !ctl.mixOut);
endmodule

// File: rtl/grain_keystream.sv
module grain_keystream
  import grain_pkg::*;
#(
  parameter int REG_W     = 80,
  parameter int IV_W      = 64,
  parameter int INIT_CLKS = 2 * REG_W,
  parameter int IDX_W     = $clog2(REG_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [REG_W-1:0] keyIn,
  input  logic [IV_W-1:0]  ivIn,
  input  logic             faultEn,
  input  logic [IDX_W-1:0] faultIdx,
  output logic             ksBit,
  output logic             ksValid,
  output logic             ready
);
  dpCtrl_t ctl;

  grain_ctrl #(.INIT_CLKS(INIT_CLKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .ctl(ctl), .ksValid(ksValid), .ready(ready)
  );

  grain_datapath #(.REG_W(REG_W), .IV_W(IV_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .keyIn(keyIn), .ivIn(ivIn),
    .faultArm(ksValid), .faultEn(faultEn), .faultIdx(faultIdx), .zBit(ksBit)
  );
endmodule

// File: tb/grain_keystream_tb.sv
module grain_keystream_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, start, faultEn;
  logic [79:0] key;
  logic [63:0] iv;
  logic [6:0]  faultIdx;
  logic        ksBit, ksValid, ready;

  int checks = 0, errors = 0;
  logic [79:0] mx, my;
  logic gotBits [0:63];
  logic refBits [0:63];

  grain_keystream u_dut (
    .clk(clk), .rstN(rstN), .start(start), .keyIn(key), .ivIn(iv),
    .faultEn(faultEn), .faultIdx(faultIdx),
    .ksBit(ksBit), .ksValid(ksValid), .ready(ready)
  );

  function automatic logic refOut(input logic [79:0] x, input logic [79:0] y);
    logic s0, s1, s2, s3, s4, h;
    s0 = y[3]; s1 = y[25]; s2 = y[46]; s3 = y[64]; s4 = x[63];
    h = s1 ^ s4 ^ (s0 & s3) ^ (s2 & s3) ^ (s3 & s4) ^ (s0 & s1 & s2)
      ^ (s0 & s2 & s3) ^ (s0 & s2 & s4) ^ (s1 & s2 & s4) ^ (s2 & s3 & s4);
    return h ^ x[1] ^ x[2] ^ x[4] ^ x[10] ^ x[31] ^ x[43] ^ x[56];
  endfunction

  function automatic logic refG(input logic [79:0] x);
    return x[0] ^ x[9] ^ x[14] ^ x[21] ^ x[28] ^ x[33] ^ x[37] ^ x[45]
         ^ x[52] ^ x[60] ^ x[62]
         ^ (x[63] & x[60]) ^ (x[37] & x[33]) ^ (x[15] & x[9])
         ^ (x[60] & x[52] & x[45]) ^ (x[33] & x[28] & x[21])
         ^ (x[63] & x[45] & x[28] & x[9]) ^ (x[60] & x[52] & x[37] & x[33])
         ^ (x[63] & x[60] & x[21] & x[15]) ^ (x[63] & x[60] & x[52] & x[45] & x[37])
         ^ (x[33] & x[28] & x[21] & x[15] & x[9])
         ^ (x[52] & x[45] & x[37] & x[33] & x[28] & x[21]);
  endfunction

  task automatic refStep(input logic mix);
    logic z, fl, fn;
    z  = refOut(mx, my) & mix;
    fl = my[0] ^ my[13] ^ my[23] ^ my[38] ^ my[51] ^ my[62] ^ z;
    fn = my[0] ^ refG(mx) ^ z;
    my = {fl, my[79:1]};
    mx = {fn, mx[79:1]};
  endtask

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", what, act, exp);
    end
  endtask

  // One full run: load, mix, then nBits keystream bits with up to two faults.
  task automatic runCase(input string tag, input logic [79:0] k, input logic [63:0] v,
                         input int nBits, input bit mixFault,
                         input int fr1, input int fi1, input int fr2, input int fi2);
    logic exp;
    key = k; iv = v;
    @(negedge clk);
    start = 1'b1; faultEn = mixFault; faultIdx = 7'd5;
    @(negedge clk);
    start = 1'b0;
    check(ksValid, 1'b0, {tag, " R8 valid low after start"});
    mx = k; my = {16'hFFFF, v};
    for (int i = 0; i < 160; i++) refStep(1'b1);
    repeat (159) @(negedge clk);
    check(ksValid, 1'b0, {tag, " R2 valid low on last mixing cycle"});
    check(ready, 1'b0, {tag, " R9 ready low while mixing"});
    @(negedge clk);
    faultEn = 1'b0;
    check(ksValid, 1'b1, {tag, " R2 valid high after 160 mixing clocks"});
    check(ready, 1'b1, {tag, " R9 ready high when running"});
    for (int n = 0; n < nBits; n++) begin
      faultEn = 1'b0;
      if (n == fr1) begin faultEn = 1'b1; faultIdx = 7'(fi1); end
      else if (n == fr2) begin faultEn = 1'b1; faultIdx = 7'(fi2); end
      if (faultEn && faultIdx < 7'd80) my[faultIdx] = ~my[faultIdx];
      #1;
      exp = refOut(mx, my);
      check(ksBit, exp, $sformatf("%s keystream bit %0d", tag, n));
      gotBits[n] = ksBit;
      refStep(1'b0);
      @(negedge clk);
    end
    faultEn = 1'b0;
  endtask

  task automatic testReset;
    check(ready, 1'b1, "R9 ready after reset");
    check(ksValid, 1'b0, "R9 valid low after reset");
  endtask

  task automatic testClean;
    runCase("R1 R3 R4 R5", 80'h0123456789ABCDEF1234, 64'h0FEDCBA987654321,
            48, 1'b0, -1, 0, -1, 0);
    runCase("R3 zero key", 80'h0, 64'h0, 32, 1'b0, -1, 0, -1, 0);
  endtask

  task automatic testMixFault;
    runCase("R6 fault ignored while mixing", 80'h0123456789ABCDEF1234,
            64'h0FEDCBA987654321, 32, 1'b1, -1, 0, -1, 0);
  endtask

  task automatic testFaults;
    runCase("R6 R7 repeated fault", 80'hA5A5_5A5A_F00F_0FF0_1357, 64'h2468_ACE0_1357_9BDF,
            48, 1'b0, 3, 40, 23, 40);
    runCase("R6 low and high index", 80'hA5A5_5A5A_F00F_0FF0_1357, 64'h2468_ACE0_1357_9BDF,
            32, 1'b0, 0, 0, 7, 79);
    runCase("R10 out of range index", 80'hA5A5_5A5A_F00F_0FF0_1357, 64'h2468_ACE0_1357_9BDF,
            24, 1'b0, 5, 95, 9, 80);
  endtask

  task automatic testRestart;
    runCase("R8 first run", 80'hFEDC_BA98_7654_3210_0F0F, 64'h1111_2222_3333_4444,
            40, 1'b0, -1, 0, -1, 0);
    for (int i = 0; i < 40; i++) refBits[i] = gotBits[i];
    runCase("R8 rerun", 80'hFEDC_BA98_7654_3210_0F0F, 64'h1111_2222_3333_4444,
            40, 1'b0, -1, 0, -1, 0);
    for (int i = 0; i < 40; i++)
      check(gotBits[i], refBits[i], $sformatf("R8 rerun matches bit %0d", i));
  endtask

  initial begin
    rstN = 1'b0; start = 1'b0; faultEn = 1'b0; faultIdx = '0; key = '0; iv = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testClean();
    testMixFault();
    testFaults();
    testRestart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule